// File: doc/BRIEF.md
# Binary Chip-Select Decoder with Synchronizer

This block sits between an SPI master and a group of SPI slaves that share one serial clock, one MOSI line and one MISO line. The master does not drive one select wire per slave. It drives a small binary code, active low, that names the slave it wants, and the all-ones code means the bus is idle. The master's serial clock runs at no more than a few MHz and has no phase relation to the fast fabric clock, so the code arrives asynchronously.

The block passes the code through a register chain in the fast clock domain (nominally 250 MHz) to resolve metastability. It accepts a new value only when the last two stages of the chain hold the same code. That value is decoded into one-hot active-low selects. Each select comes from its own flip-flop, so a select never glitches while the code bits change at slightly different times. Select index 0 goes to a slave on the same chip. The remaining indices go to external slaves. The master asserts a select half a serial-clock period before the first active edge, and the whole decode path must fit inside that window. At 5 MHz the window is 100 ns, or 25 fast cycles, and the block needs four.

Top module: `cs_binary_decoder`

## Requirements
- R1: While `rstN` is low, every select output is high. Reset acts asynchronously and also clears the synchronizer chain to the idle code.
- R2: Code 0 drives `localCsN` low, and every bit of `extCsN` stays high.
- R3: A code k in the range 1 to NUM_CS-1 (1 to 5 by default) drives `extCsN[k-1]` low. Every other output stays high.
- R4: The all-ones code (7 with the default 3-bit code) is idle, and every output reads high.
- R5: A code from NUM_CS up to 2^CODE_W-2 (only code 6 by default) selects nothing, and every output reads high.
- R6: A code that changes just before a rising edge and then stays steady reaches the outputs on the fourth rising edge (SYNC_STAGES+2). After the third edge the outputs still show the previous decode.
- R7: The outputs change only at an edge where the last two synchronizer stages agree. A code present at the input for a single fast-clock sample therefore never produces a select.
- R8: At most one output is low at any time. This includes a direct switch from one selected slave to another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast decode clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selCode | input | CODE_W | Binary select code from the SPI master; asynchronous; all ones is idle |
| localCsN | output | 1 | Active-low select for the on-chip slave (code 0) |
| extCsN | output | NUM_CS-1 | Active-low selects for the external slaves; bit k-1 answers code k |

## Verification
A code driven just after a falling edge shows no effect after three rising edges and its full decode after the fourth. Each table step samples at the falling edge after the third rising edge, expecting the previous decode, and again after the fourth, expecting the new one. The single-sample transient test and the direct-switch steps sample at every falling edge over the whole settling window. This checks that the skipped code never appears and that no two selects are low together. The reset test samples one nanosecond after `rstN` falls, to show that reset does not wait for a clock edge.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic load;      // last two synchronizer stages agree
    logic selValid;  // the agreed code names an existing slave
  } dec_strobe_t;

endpackage

// File: rtl/cs_dec_ctrl.sv
module cs_dec_ctrl
  import cs_dec_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter int NUM_CS = 6
) (
  input  logic [CODE_W-1:0] tailCode,
  input  logic [CODE_W-1:0] prevCode,
  output dec_strobe_t       strobe
);

  localparam logic [CODE_W-1:0] IDLE_CODE = {CODE_W{1'b1}};

  logic isIdle;
  logic inRange;

  always_comb begin
    isIdle          = (tailCode == IDLE_CODE);
    inRange         = (int'(tailCode) < NUM_CS);
    strobe.load     = (tailCode == prevCode);
    strobe.selValid = inRange && !isIdle;
  end

endmodule

// File: rtl/cs_dec_datapath.sv
module cs_dec_datapath
  import cs_dec_pkg::*;
#(
  parameter int CODE_W      = 3,
  parameter int NUM_CS      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] selCode,
  input  dec_strobe_t       strobe,
  output logic [CODE_W-1:0] tailCode,
  output logic [CODE_W-1:0] prevCode,
  output logic [NUM_CS-1:0] csN
);

  localparam int CHAIN_LEN = SYNC_STAGES + 1;
  localparam logic [CODE_W-1:0] IDLE_CODE = {CODE_W{1'b1}};

  logic [CHAIN_LEN-1:0][CODE_W-1:0] stg;

  // Synchronizer chain; the final stage acts as the qualification copy.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg[0] <= IDLE_CODE;
    else       stg[0] <= selCode;
  end

  genvar s;
  generate
    for (s = 1; s < CHAIN_LEN; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg[s] <= IDLE_CODE;
        else       stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign tailCode = stg[CHAIN_LEN-1];
  assign prevCode = stg[CHAIN_LEN-2];

  // One flip-flop per select output.
  genvar i;
  generate
    for (i = 0; i < NUM_CS; i++) begin : g_out
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          csN[i] <= 1'b1;
        else if (strobe.load)
          csN[i] <= !(strobe.selValid && (tailCode == CODE_W'(i)));
      end
    end
  endgenerate

endmodule

// File: rtl/cs_binary_decoder.sv
module cs_binary_decoder
  import cs_dec_pkg::*;
#(
  parameter int CODE_W      = 3,
  parameter int NUM_CS      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] selCode,
  output logic              localCsN,
  output logic [NUM_CS-2:0] extCsN
);

  dec_strobe_t       strobe;
  logic [CODE_W-1:0] tailCode;
  logic [CODE_W-1:0] prevCode;
  logic [NUM_CS-1:0] csN;

  cs_dec_datapath #(
    .CODE_W     (CODE_W),
    .NUM_CS     (NUM_CS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .selCode (selCode),
    .strobe  (strobe),
    .tailCode(tailCode),
    .prevCode(prevCode),
    .csN     (csN)
  );

  cs_dec_ctrl #(
    .CODE_W(CODE_W),
    .NUM_CS(NUM_CS)
  ) u_ctrl (
    .tailCode(tailCode),
    .prevCode(prevCode),
    .strobe  (strobe)
  );

  assign localCsN = csN[0];
  assign extCsN   = csN[NUM_CS-1:1];

endmodule

// File: rtl/cs_binary_decoder_chk.sv
module cs_binary_decoder_chk
  import cs_dec_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter int NUM_CS = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              localCsN,
  input logic [NUM_CS-2:0] extCsN,
  input logic [CODE_W-1:0] tailCode,
  input dec_strobe_t       strobe
);

  logic [NUM_CS-1:0] allCsN;
  assign allCsN = {extCsN, localCsN};

  // R1
  reset_high_chk: assert property (@(posedge clk)
    !rstN |=> (allCsN == {NUM_CS{1'b1}}));

  // R2
  local_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && tailCode == '0) |=> (!localCsN && extCsN == {(NUM_CS-1){1'b1}}));

  // R4
  idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && (&tailCode)) |=> (allCsN == {NUM_CS{1'b1}}));

  // R5
  unused_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && int'(tailCode) >= NUM_CS) |=> (allCsN == {NUM_CS{1'b1}}));

  // R7
  hold_on_mismatch_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(allCsN));

  // R8
  single_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~allCsN));

endmodule

bind cs_binary_decoder cs_binary_decoder_chk #(
  .CODE_W(CODE_W),
  .NUM_CS(NUM_CS)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .localCsN(localCsN),
  .extCsN  (extCsN),
  .tailCode(tailCode),
  .strobe  (strobe)
);

// File: tb/cs_binary_decoder_tb.sv
module cs_binary_decoder_tb;

  localparam int CODE_W = 3;
  localparam int NUM_CS = 6;
  localparam int NVEC   = 11;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [CODE_W-1:0] selCode = 3'b111;
  logic              localCsN;
  logic [NUM_CS-2:0] extCsN;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cs_binary_decoder #(.CODE_W(CODE_W), .NUM_CS(NUM_CS), .SYNC_STAGES(2)) u_dut (
    .clk     (clk),
    .rstN    (rstN),
    .selCode (selCode),
    .localCsN(localCsN),
    .extCsN  (extCsN)
  );

  // {code[2:0], expected {extCsN[4:0], localCsN}}
  localparam logic [8:0] VEC [NVEC] = '{
    {3'd0, 6'b111110}, {3'd1, 6'b111101}, {3'd2, 6'b111011},
    {3'd3, 6'b110111}, {3'd4, 6'b101111}, {3'd5, 6'b011111},
    {3'd7, 6'b111111}, {3'd6, 6'b111111}, {3'd5, 6'b011111},
    {3'd0, 6'b111110}, {3'd4, 6'b101111}
  };

  function automatic logic [5:0] outs();
    return {extCsN, localCsN};
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic checkOneLow(input string req);
    checks++;
    if (!$onehot0(~outs())) begin
      fails++;
      $display("FAIL %s: actual %b expected at most one low bit", req, outs());
    end
  endtask

  function automatic string reqOf(input logic [2:0] c);
    if (c == 3'd0) return "R2";
    if (c == 3'd7) return "R4";
    if (c == 3'd6) return "R5";
    return "R3";
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [5:0] prevExp;
    repeat (3) @(negedge clk);
    check("R1", outs(), 6'b111111);
    rstN = 1'b1;
    repeat (6) @(negedge clk);
    check("R4", outs(), 6'b111111);

    // Table walk: latency (R6) and decode (R2..R5), one-low (R8).
    prevExp = 6'b111111;
    for (int v = 0; v < NVEC; v++) begin
      selCode = VEC[v][8:6];
      for (int e = 0; e < 3; e++) begin
        @(negedge clk);
        checkOneLow("R8");
      end
      check("R6", outs(), prevExp);
      @(negedge clk);
      check(reqOf(VEC[v][8:6]), outs(), VEC[v][5:0]);
      checkOneLow("R8");
      prevExp = VEC[v][5:0];
      repeat (2) @(negedge clk);
    end

    // R7: single-sample code 3 between codes 1 and 2 never selects.
    selCode = 3'd1;
    repeat (6) @(negedge clk);
    check("R3", outs(), 6'b111101);
    selCode = 3'd3;
    @(negedge clk);
    selCode = 3'd2;
    for (int e = 0; e < 8; e++) begin
      @(negedge clk);
      checks++;
      if (extCsN[2] !== 1'b1) begin
        fails++;
        $display("FAIL R7: actual extCsN[2]=%b expected 1", extCsN[2]);
      end
      checkOneLow("R8");
    end
    check("R3", outs(), 6'b111011);

    // R1: asynchronous reset mid-selection.
    @(negedge clk);
    #1 rstN = 1'b0;
    #1 check("R1", outs(), 6'b111111);
    @(negedge clk);
    rstN = 1'b1;
    repeat (6) @(negedge clk);
    check("R3", outs(), 6'b111011);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule